// File: doc/BRIEF.md
# Level-Sensed Single-Transfer DMA Channel

This block is one DMA channel driven by an external, active-low transfer request that is sensed by level. After software arms the channel through a small register port, the controller looks at the request pin on every clock edge. A low level there latches a pending request and raises a bus request to an external arbiter. Once the grant is seen, the pending request is dropped. The channel then performs one read at the source address and one write of the captured data to the destination address. It releases the bus and opens acceptance again.

Each read or write holds its strobe until the memory answers with ready. Both addresses can be held fixed, stepped up or stepped down by the unit size after their own cycle. A transfer counter counts the read/write pairs. When it runs out, the channel disarms itself and raises a done flag. Requests are not accepted while one is already in flight, so a pin that is held low gives exactly one transfer per pass of the read/write sequence.

Top module: `lxc_channel`

## Requirements
- R1: After reset, busReq, memRd, memWr and done are all 0.
- R2: Request sampling starts on the first rising edge after the edge that captures the register write setting the enable bit (cfgSel=3, bit 0 = 1). A pin already low during that write raises busReq only after that next edge. While the channel is disabled, a low pin never raises busReq.
- R3: While acceptance is open, a low pin at a rising edge latches a pending request, and busReq is 1 from the following cycle. The pending request is cleared on the edge that sees busGrant. The channel then asserts memRd with memAddr equal to the source address until memReady is seen.
- R4: The cycle after a read completes, the channel asserts memWr with memAddr equal to the destination address and memWdata equal to the data read. It holds them until memReady is seen.
- R5: From the latch of a request until its write completes, the pin is ignored. A low pulse during that window causes no extra transfer.
- R6: busReq drops in the cycle after the write completes. With the pin held low, it rises again after exactly one cycle low, because sampling resumes on the next edge.
- R7: Address stepping is set in the control register at cfgSel=3. Bits [2:1] select the source mode and bits [4:3] the destination mode: 0 or 3 = fixed, 1 = increment, 2 = decrement. Bits [6:5] select the step size: 0 = 1, 1 = 2, 2 or 3 = 4. The source address steps after its read and the destination address after its write.
- R8: The transfer count is written at cfgSel=2, and writing 0 means 65536 pairs. It drops by one after each write. When it reaches zero, the enable bit clears and done goes to 1, and a low pin no longer raises busReq.
- R9: Writing the control register with bit 0 = 1 clears done.
- R10: Source (cfgSel=0), destination (cfgSel=1), count and control writes are ignored while a request is pending or a read/write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfgData | input | 32 | Register write data |
| xferReqN | input | 1 | External transfer request, active low, level sensed |
| busReq | output | 1 | Bus request to arbiter |
| busGrant | input | 1 | Bus grant from arbiter |
| memAddr | output | 24 | Memory address |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data |
| memReady | input | 1 | Cycle completion from memory |
| done | output | 1 | Transfer count exhausted |

## Verification
Several pin patterns are used. A pin held low before arming shows the one-edge start delay. A pin held low through a whole run shows the one-cycle gap between transfers and the stop at count zero. Single-cycle pulses, one of them landing inside a read with wait states, separate a correctly gated acceptance window from one that counts extra transfers. Runs with different step modes, sizes and wait states, plus a register write attempted mid-transfer, confirm the address sequence and that the register port is locked while busy.

// File: rtl/lxc_pkg.sv
package lxc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgOpen;    // register port may update
    logic selDst;     // drive destination on memAddr
    logic loadBuf;    // capture read data
    logic stepSrc;    // advance source address
    logic stepDst;    // advance destination address
    logic countDown;  // one pair finished
  } dpStrobe_t;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam logic [1:0] MODE_INC = 2'd1;
  localparam logic [1:0] MODE_DEC = 2'd2;

endpackage

// File: rtl/lxc_datapath.sv
module lxc_datapath
  import lxc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              enableQ,
  output logic              done
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] srcQ, dstQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] bufQ;
  logic [1:0]        srcMode, dstMode, sizeCode;
  logic [2:0]        stepVal;
  logic              cfgHit;
  logic              unusedCfg;

  assign unusedCfg = ^cfgData;
  assign cfgHit    = cfgWe && strobe.cfgOpen;

  always_comb begin
    case (sizeCode)
      2'd0:    stepVal = 3'd1;
      2'd1:    stepVal = 3'd2;
      default: stepVal = 3'd4;
    endcase
  end

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                input logic [1:0] mode,
                                                input logic [2:0] step);
    case (mode)
      MODE_INC: advance = a + ADDR_W'(step);
      MODE_DEC: advance = a - ADDR_W'(step);
      default:  advance = a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ     <= '0;
      dstQ     <= '0;
      cntQ     <= '0;
      srcMode  <= '0;
      dstMode  <= '0;
      sizeCode <= '0;
      enableQ  <= 1'b0;
      done     <= 1'b0;
      bufQ     <= '0;
    end else begin
      if (strobe.loadBuf) bufQ <= memRdata;
      if (strobe.stepSrc) srcQ <= advance(srcQ, srcMode, stepVal);
      if (strobe.stepDst) dstQ <= advance(dstQ, dstMode, stepVal);
      if (strobe.countDown) begin
        cntQ <= cntQ - 1'b1;
        if (cntQ == CNT_ONE) begin
          enableQ <= 1'b0;
          done    <= 1'b1;
        end
      end
      if (cfgHit) begin
        case (cfgSel)
          SEL_SRC: srcQ <= cfgData[ADDR_W-1:0];
          SEL_DST: dstQ <= cfgData[ADDR_W-1:0];
          SEL_CNT: cntQ <= cfgData[CNT_W-1:0];
          default: begin
            enableQ  <= cfgData[0];
            srcMode  <= cfgData[2:1];
            dstMode  <= cfgData[4:3];
            sizeCode <= cfgData[6:5];
            if (cfgData[0]) done <= 1'b0;
          end
        endcase
      end
    end
  end

  assign memAddr  = strobe.selDst ? dstQ : srcQ;
  assign memWdata = bufQ;

  // R8: each finished pair lowers the count by one
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countDown |=> (cntQ == $past(cntQ) - 1'b1));

  // R8: raising done always disarms the channel
  a_r8_done_disarms: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !enableQ);

  // R10: registers hold while the port is locked
  a_r10_locked_src: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cfgOpen && !strobe.stepSrc) |=> $stable(srcQ));

endmodule

// File: rtl/lxc_control.sv
module lxc_control
  import lxc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      xferReqN,
  input  logic      enableQ,
  input  logic      busGrant,
  input  logic      memReady,
  output logic      busReq,
  output logic      memRd,
  output logic      memWr,
  output dpStrobe_t strobe
);

  chanState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (enableQ && !xferReqN) stateD = ST_PEND;
      ST_PEND:  if (busGrant)             stateD = ST_READ;
      ST_READ:  if (memReady)             stateD = ST_WRITE;
      ST_WRITE: if (memReady)             stateD = ST_IDLE;
      default:                            stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busReq = (stateQ != ST_IDLE);
  assign memRd  = (stateQ == ST_READ);
  assign memWr  = (stateQ == ST_WRITE);

  always_comb begin
    strobe           = '0;
    strobe.cfgOpen   = (stateQ == ST_IDLE);
    strobe.selDst    = (stateQ == ST_WRITE);
    strobe.loadBuf   = (stateQ == ST_READ) && memReady;
    strobe.stepSrc   = (stateQ == ST_READ) && memReady;
    strobe.stepDst   = (stateQ == ST_WRITE) && memReady;
    strobe.countDown = (stateQ == ST_WRITE) && memReady;
  end

  // R3: a granted pending request starts a read
  a_r3_grant_to_read: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PEND && busGrant) |=> memRd);

  // R4: a completed read is followed by a write
  a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memReady) |=> memWr);

  // R6: bus released after the write
  a_r6_release_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && memReady) |=> !busReq);

  // R2: no acceptance while disabled
  a_r2_idle_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !enableQ) |=> !busReq);

  // R5: read and write never overlap
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

endmodule

// File: rtl/lxc_channel.sv
module lxc_channel
  import lxc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              xferReqN,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              done
);

  dpStrobe_t strobe;
  logic      enableQ;

  lxc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .xferReqN (xferReqN),
    .enableQ  (enableQ),
    .busGrant (busGrant),
    .memReady (memReady),
    .busReq   (busReq),
    .memRd    (memRd),
    .memWr    (memWr),
    .strobe   (strobe)
  );

  lxc_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgData  (cfgData),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .enableQ  (enableQ),
    .done     (done)
  );

endmodule

// File: tb/lxc_channel_test.sv
`timescale 1ns/1ps
module lxc_channel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgData = '0;
  logic        xferReqN = 1'b1;
  logic        busReq;
  logic        busGrant = 1'b0;
  logic [23:0] memAddr;
  logic        memRd, memWr;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        memReady = 1'b0;
  logic        done;

  int tests = 0;
  int fails = 0;
  int waitStates = 0;
  int waitCnt = 0;

  logic [31:0] mem [0:255];
  logic [23:0] rdLog [0:63];
  logic [23:0] wrLog [0:63];
  logic [31:0] wdLog [0:63];
  int nRd = 0;
  int nWr = 0;

  always #4 clk = ~clk;

  lxc_channel uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .xferReqN(xferReqN), .busReq(busReq), .busGrant(busGrant),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .done(done)
  );

  function automatic logic [31:0] initWord(input int i);
    return 32'hC0DE_0000 + 32'(i);
  endfunction

  // arbiter: grant follows request one cycle later
  always @(posedge clk) busGrant <= busReq;

  // memory model with wait states
  assign memRdata = mem[memAddr[7:0]];
  initial for (int i = 0; i < 256; i++) mem[i] = initWord(i);

  always @(posedge clk) begin
    if (memReady) begin
      memReady <= 1'b0;
      waitCnt  <= 0;
      if (memWr) mem[memAddr[7:0]] <= memWdata;
    end else if (memRd || memWr) begin
      if (waitCnt >= waitStates) memReady <= 1'b1;
      else waitCnt <= waitCnt + 1;
    end
  end

  always @(posedge clk) begin
    if (memRd && memReady) begin
      rdLog[nRd & 63] <= memAddr;
      nRd <= nRd + 1;
    end
    if (memWr && memReady) begin
      wrLog[nWr & 63] <= memAddr;
      wdLog[nWr & 63] <= memWdata;
      nWr <= nWr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk); xferReqN = 1'b0;
    @(negedge clk); xferReqN = 1'b1;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  task automatic waitRead();
    for (int i = 0; i < 200 && !memRd; i++) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && busReq; i++) @(negedge clk);
  endtask

  // R1
  task automatic testReset();
    @(negedge clk);
    check(!busReq && !memRd && !memWr && !done, "R1", "outputs after reset",
          {28'd0, busReq, memRd, memWr, done}, 32'd0);
  endtask

  // R2: disabled channel ignores pin
  task automatic testDisabled(input string req);
    @(negedge clk); xferReqN = 1'b0;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (busReq) seen = 1'b1;
      end
      check(!seen, req, "busReq with channel disabled", {31'd0, seen}, 32'd0);
    end
    xferReqN = 1'b1;
  endtask

  // R3 R4 R6 R7 R8: held pin, increment, byte step
  task automatic testHeldIncrement();
    int b = nWr;
    int r = nRd;
    cfgWrite(2'd0, 32'h10);
    cfgWrite(2'd1, 32'h80);
    cfgWrite(2'd2, 32'd3);
    @(negedge clk); xferReqN = 1'b0;
    cfgWrite(2'd3, 32'h0B); // enable, src inc, dst inc, size 1
    // R6: gap between transfers with pin held low
    for (int i = 0; i < 200 && !(memWr && memReady); i++) @(negedge clk);
    @(negedge clk);
    check(!busReq, "R6", "busReq after write", {31'd0, busReq}, 32'd0);
    @(negedge clk);
    check(busReq, "R6", "busReq one cycle later", {31'd0, busReq}, 32'd1);
    waitDone();
    xferReqN = 1'b1;
    @(negedge clk);
    check(nWr - b == 3, "R8", "writes for count 3", 32'(nWr - b), 32'd3);
    for (int k = 0; k < 3; k++) begin
      check(rdLog[(r + k) & 63] == 24'h10 + 24'(k), "R3", "read address",
            {8'd0, rdLog[(r + k) & 63]}, 32'h10 + 32'(k));
      check(wrLog[(b + k) & 63] == 24'h80 + 24'(k), "R7", "dest address inc",
            {8'd0, wrLog[(b + k) & 63]}, 32'h80 + 32'(k));
      check(wdLog[(b + k) & 63] == initWord(16 + k), "R4", "written data",
            wdLog[(b + k) & 63], initWord(16 + k));
    end
    check(done, "R8", "done after count", {31'd0, done}, 32'd1);
    testDisabled("R8");
  endtask

  // R7 R9: decrement source by 4, fixed destination
  task automatic testDecFixed();
    int b = nWr;
    int r = nRd;
    waitStates = 2;
    cfgWrite(2'd0, 32'h40);
    cfgWrite(2'd1, 32'hF0);
    cfgWrite(2'd2, 32'd2);
    cfgWrite(2'd3, 32'h45); // enable, src dec, dst fixed, size 4
    check(!done, "R9", "done cleared by enable", {31'd0, done}, 32'd0);
    @(negedge clk); xferReqN = 1'b0;
    waitDone();
    xferReqN = 1'b1;
    @(negedge clk);
    check(rdLog[(r + 1) & 63] == 24'h3C, "R7", "source dec by 4",
          {8'd0, rdLog[(r + 1) & 63]}, 32'h3C);
    check(wrLog[(b + 1) & 63] == 24'hF0, "R7", "dest fixed",
          {8'd0, wrLog[(b + 1) & 63]}, 32'hF0);
    check(mem[8'hF0] == initWord(8'h3C), "R4", "final dest word",
          mem[8'hF0], initWord(8'h3C));
  endtask

  // R2: start edge after enable write
  task automatic testStartEdge();
    cfgWrite(2'd0, 32'h50);
    cfgWrite(2'd1, 32'hA0);
    cfgWrite(2'd2, 32'd1);
    @(negedge clk); xferReqN = 1'b0;
    cfgWrite(2'd3, 32'h01);
    check(!busReq, "R2", "busReq at enable edge", {31'd0, busReq}, 32'd0);
    @(negedge clk);
    check(busReq, "R2", "busReq one edge later", {31'd0, busReq}, 32'd1);
    xferReqN = 1'b1;
    waitDone();
    check(done, "R2", "single transfer done", {31'd0, done}, 32'd1);
  endtask

  // R5: pulses inside the busy window are ignored
  task automatic testGating();
    int b = nWr;
    waitStates = 3;
    cfgWrite(2'd0, 32'h60);
    cfgWrite(2'd1, 32'hB0);
    cfgWrite(2'd2, 32'd2);
    cfgWrite(2'd3, 32'h01);
    pulseReq();
    waitRead();
    pulseReq();
    for (int i = 0; i < 40; i++) @(negedge clk);
    check(nWr - b == 1, "R5", "transfers after busy pulse", 32'(nWr - b), 32'd1);
    check(!done && !busReq, "R5", "still armed and idle",
          {30'd0, done, busReq}, 32'd0);
    pulseReq();
    waitDone();
    check(nWr - b == 2, "R5", "second pulse accepted", 32'(nWr - b), 32'd2);
  endtask

  // R10: register writes locked while busy
  task automatic testLock();
    int r = nRd;
    waitStates = 5;
    cfgWrite(2'd0, 32'h20);
    cfgWrite(2'd1, 32'h90);
    cfgWrite(2'd2, 32'd2);
    cfgWrite(2'd3, 32'h0B);
    pulseReq();
    waitRead();
    cfgWrite(2'd0, 32'h00);
    waitIdle();
    pulseReq();
    waitDone();
    @(negedge clk);
    check(rdLog[(r + 1) & 63] == 24'h21, "R10", "source after locked write",
          {8'd0, rdLog[(r + 1) & 63]}, 32'h21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDisabled("R2");
    testHeldIncrement();
    testDecFixed();
    testStartEdge();
    testGating();
    testLock();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule